// File: doc/BRIEF.md
# Credit-Gated Logical Channel Controller

This block runs one logical channel between a local (host-side) client and a remote firmware client over a shared message bus. A local connect command makes it emit a connect request. The peer's connect response then either opens the channel or returns the block to idle with an error flag raised. While the channel is open, every outgoing data message needs a credit that the peer granted beforehand. Each credit covers exactly one message. A send command that arrives with no credit in hand is held and goes out on its own as soon as the next credit arrives.

In the other direction, the block grants the peer one credit whenever the local receive buffer reports room, and it never has more than one grant outstanding. A data message from the peer uses up that grant. Either side may close the channel. A firmware link reset drops it at once. In every case the held send and both credit flags are cleared. Payload storage and client identity lookup belong to the surrounding logic. This block only carries the host and firmware client IDs of the current connection.

Top module: `chan_flow_ctrl`

## Requirements
- R1: A connect command in IDLE produces a one-cycle connect-request pulse on the next cycle, moves the state to CONNECTING (code 1) and latches both client IDs onto the ID outputs. A connect command in any other state has no effect.
- R2: In CONNECTING, a connect response with the ok bit set moves to CONNECTED (code 2). With the ok bit clear it moves to IDLE (code 0) and sets the error flag. The error flag stays set until the next accepted connect command.
- R3: A send command outside CONNECTED is dropped. No data pulse is emitted and no pending send is recorded.
- R4: In CONNECTED, a send command with a credit available (held, or arriving in the same cycle) produces one data pulse on the next cycle and uses up the credit.
- R5: In CONNECTED, a send command without a credit sets the pending flag. The data pulse follows on the cycle after the next credit arrives, and the pending flag clears.
- R6: Credits and sends do not accumulate. A second credit while one is held is absorbed, a second send while one is pending is absorbed, and the pending and credit-available flags are never both set.
- R7: In CONNECTED, when the receive buffer reports a free slot and no grant is outstanding, a one-cycle credit pulse goes to the peer and the outstanding flag sets. The flag clears when a peer data message arrives.
- R8: A local disconnect command in CONNECTING or CONNECTED produces a one-cycle disconnect-request pulse and moves to DISCONNECTING (code 3), clearing all credit and pending flags. A peer disconnect request then returns the state to IDLE.
- R9: A link reset or peer disconnect request in any state returns the state to IDLE on the next cycle and clears all flags. It takes priority over any local command in the same cycle.
- R10: During and after asynchronous reset the state is IDLE, all pulses and flags are low and the IDs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_connect | input | 1 | Local request to open the channel |
| cmd_disconnect | input | 1 | Local request to close the channel |
| cmd_send | input | 1 | Local request to send one data message |
| host_id_i | input | ID_W | Host client ID offered with a connect |
| fw_id_i | input | ID_W | Firmware client ID offered with a connect |
| ev_conn_resp | input | 1 | Connect response received |
| ev_conn_ok | input | 1 | Status bit of the connect response, 1 = accepted |
| ev_credit | input | 1 | Flow-control credit received from peer |
| ev_disc_req | input | 1 | Disconnect request received from peer |
| ev_link_reset | input | 1 | Firmware link reset |
| ev_peer_data | input | 1 | Data message received from peer |
| rx_slot_free | input | 1 | Local receive buffer has room (level) |
| tx_conn_req | output | 1 | Emit connect request (pulse) |
| tx_disc_req | output | 1 | Emit disconnect request (pulse) |
| tx_data | output | 1 | Emit one data message (pulse) |
| tx_credit | output | 1 | Emit one credit to peer (pulse) |
| msg_host_id | output | ID_W | Host client ID of the connection |
| msg_fw_id | output | ID_W | Firmware client ID of the connection |
| state_o | output | 2 | 0 IDLE, 1 CONNECTING, 2 CONNECTED, 3 DISCONNECTING |
| conn_err | output | 1 | Last connect attempt was refused |
| credit_avail | output | 1 | A peer credit is held |
| send_pending | output | 1 | A send waits for a credit |
| credit_out | output | 1 | A grant to the peer is outstanding |

## Verification
The assertions check the following properties on every cycle:
- Data and credit pulses only ever follow a cycle spent in CONNECTED.
- A pending send and a held credit never coexist.
- A second grant is never issued while one is outstanding.
- A link reset always leaves the block idle and flushed.
- Entry into CONNECTED is only ever preceded by an accepted response.

The bench scenarios cover the behaviour that needs history:
- A held send firing on a later credit.
- Surplus credits and sends being absorbed.
- The error flag persisting until the next connect.
- IDs staying latched across a session.
- The priority of a peer close over a same-cycle local command.

A reference model run under a long random mix of commands and events catches ordering slips between these paths.

// File: rtl/chan_flow_pkg.sv
package chan_flow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_CONNECTING = 2'd1,
    ST_CONNECTED  = 2'd2,
    ST_CLOSING    = 2'd3
  } chan_state_e;
endpackage

// File: rtl/chan_conn_fsm.sv
module chan_conn_fsm
  import chan_flow_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_connect,
  input  logic            cmd_disconnect,
  input  logic            ev_conn_resp,
  input  logic            ev_conn_ok,
  input  logic            ev_disc_req,
  input  logic            ev_link_reset,
  input  logic [ID_W-1:0] host_id_i,
  input  logic [ID_W-1:0] fw_id_i,
  output chan_state_e     state_o,
  output logic            conn_req_o,
  output logic            disc_req_o,
  output logic            err_o,
  output logic [ID_W-1:0] host_id_o,
  output logic [ID_W-1:0] fw_id_o
);
  chan_state_e     st_q, st_d;
  logic            creq_d, dreq_d, err_d, id_en;

  always_comb begin
    st_d   = st_q;
    creq_d = 1'b0;
    dreq_d = 1'b0;
    err_d  = err_o;
    id_en  = 1'b0;
    if (ev_link_reset || ev_disc_req) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_connect) begin
          st_d   = ST_CONNECTING;
          creq_d = 1'b1;
          err_d  = 1'b0;
          id_en  = 1'b1;
        end
        ST_CONNECTING: begin
          if (cmd_disconnect) begin
            st_d   = ST_CLOSING;
            dreq_d = 1'b1;
          end else if (ev_conn_resp) begin
            st_d  = ev_conn_ok ? ST_CONNECTED : ST_IDLE;
            err_d = !ev_conn_ok;
          end
        end
        ST_CONNECTED: if (cmd_disconnect) begin
          st_d   = ST_CLOSING;
          dreq_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      conn_req_o <= 1'b0;
      disc_req_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      st_q       <= st_d;
      conn_req_o <= creq_d;
      disc_req_o <= dreq_d;
      err_o      <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_id_o <= '0;
      fw_id_o   <= '0;
    end else if (id_en) begin
      host_id_o <= host_id_i;
      fw_id_o   <= fw_id_i;
    end
  end

  assign state_o = st_q;

  // R1: a connect request leaves from IDLE and lands in CONNECTING
  a_r1_conn_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    conn_req_o |-> ($past(st_q) == ST_IDLE) && (st_q == ST_CONNECTING));

  // R2: CONNECTED is only entered through an accepted response
  a_r2_open_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONNECTED && $past(st_q) != ST_CONNECTED)
      |-> ($past(st_q) == ST_CONNECTING) && $past(ev_conn_resp && ev_conn_ok));

  // R9: a link reset always lands in IDLE
  a_r9_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_link_reset) |-> (st_q == ST_IDLE) && !conn_req_o && !disc_req_o);
endmodule

// File: rtl/chan_tx_gate.sv
module chan_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cmd_send,
  input  logic ev_credit,
  output logic data_o,
  output logic credit_avail_o,
  output logic pending_o
);
  logic have_cr, want_tx, fire;
  logic cav_d, pend_d;

  always_comb begin
    have_cr = credit_avail_o | ev_credit;
    want_tx = pending_o | cmd_send;
    fire    = active & have_cr & want_tx;
    cav_d   = active & have_cr & !fire;
    pend_d  = active & want_tx & !fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o         <= 1'b0;
      credit_avail_o <= 1'b0;
      pending_o      <= 1'b0;
    end else begin
      data_o         <= fire;
      credit_avail_o <= cav_d;
      pending_o      <= pend_d;
    end
  end

  // R6: a held send and a held credit never coexist
  a_r6_no_pend_with_credit: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending_o && credit_avail_o));

  // R4: a data pulse always drains the credit that was held or arriving
  a_r4_data_drains_credit: assert property (@(posedge clk) disable iff (!rst_n)
    data_o |-> !credit_avail_o || $past(ev_credit && credit_avail_o));
endmodule

// File: rtl/chan_rx_grant.sv
module chan_rx_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rx_slot_free,
  input  logic ev_peer_data,
  output logic credit_o,
  output logic out_o
);
  logic issue, out_d;

  always_comb begin
    issue = active & rx_slot_free & !out_o;
    out_d = active & ((out_o & !ev_peer_data) | issue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_o <= 1'b0;
      out_o    <= 1'b0;
    end else begin
      credit_o <= issue;
      out_o    <= out_d;
    end
  end

  // R7: never a second grant while one is outstanding
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    credit_o |-> !$past(out_o) && out_o);
endmodule

// File: rtl/chan_flow_ctrl.sv
module chan_flow_ctrl
  import chan_flow_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_connect,
  input  logic            cmd_disconnect,
  input  logic            cmd_send,
  input  logic [ID_W-1:0] host_id_i,
  input  logic [ID_W-1:0] fw_id_i,
  input  logic            ev_conn_resp,
  input  logic            ev_conn_ok,
  input  logic            ev_credit,
  input  logic            ev_disc_req,
  input  logic            ev_link_reset,
  input  logic            ev_peer_data,
  input  logic            rx_slot_free,
  output logic            tx_conn_req,
  output logic            tx_disc_req,
  output logic            tx_data,
  output logic            tx_credit,
  output logic [ID_W-1:0] msg_host_id,
  output logic [ID_W-1:0] msg_fw_id,
  output logic [1:0]      state_o,
  output logic            conn_err,
  output logic            credit_avail,
  output logic            send_pending,
  output logic            credit_out
);
  chan_state_e st;
  logic        teardown, active;

  assign teardown = ev_link_reset | ev_disc_req | cmd_disconnect;
  assign active   = (st == ST_CONNECTED) & !teardown;
  assign state_o  = st;

  chan_conn_fsm #(.ID_W(ID_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_connect(cmd_connect), .cmd_disconnect(cmd_disconnect),
    .ev_conn_resp(ev_conn_resp), .ev_conn_ok(ev_conn_ok),
    .ev_disc_req(ev_disc_req), .ev_link_reset(ev_link_reset),
    .host_id_i(host_id_i), .fw_id_i(fw_id_i),
    .state_o(st), .conn_req_o(tx_conn_req), .disc_req_o(tx_disc_req),
    .err_o(conn_err), .host_id_o(msg_host_id), .fw_id_o(msg_fw_id)
  );

  chan_tx_gate u_tx (
    .clk(clk), .rst_n(rst_n), .active(active),
    .cmd_send(cmd_send), .ev_credit(ev_credit),
    .data_o(tx_data), .credit_avail_o(credit_avail), .pending_o(send_pending)
  );

  chan_rx_grant u_rx (
    .clk(clk), .rst_n(rst_n), .active(active),
    .rx_slot_free(rx_slot_free), .ev_peer_data(ev_peer_data),
    .credit_o(tx_credit), .out_o(credit_out)
  );

  // R3: data and credit pulses only follow a cycle in CONNECTED
  a_r3_traffic_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data || tx_credit) |-> $past(st) == ST_CONNECTED);

  // R8: flags are empty whenever the channel is not open
  a_r8_flags_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_CONNECTED) |-> !credit_avail && !send_pending && !credit_out);
endmodule

// File: tb/chan_flow_ctrl_test.sv
module chan_flow_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_connect, cmd_disconnect, cmd_send;
  logic [ID_W-1:0] host_id_i, fw_id_i;
  logic ev_conn_resp, ev_conn_ok, ev_credit, ev_disc_req, ev_link_reset;
  logic ev_peer_data, rx_slot_free;
  logic tx_conn_req, tx_disc_req, tx_data, tx_credit;
  logic [ID_W-1:0] msg_host_id, msg_fw_id;
  logic [1:0] state_o;
  logic conn_err, credit_avail, send_pending, credit_out;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [1:0] m_st;
  logic m_creq, m_dreq, m_data, m_cred, m_cav, m_pend, m_cout, m_err;
  logic [ID_W-1:0] m_hid, m_fid;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_flow_ctrl #(.ID_W(ID_W)) uut (.*);

  function automatic logic [2*ID_W+10:0] pack_exp();
    return {m_st, m_creq, m_dreq, m_data, m_cred, m_cav, m_pend, m_cout, m_err, m_hid, m_fid};
  endfunction

  function automatic logic [2*ID_W+10:0] pack_act();
    return {state_o, tx_conn_req, tx_disc_req, tx_data, tx_credit, credit_avail,
            send_pending, credit_out, conn_err, msg_host_id, msg_fw_id};
  endfunction

  task automatic check(string tag);
    checks++;
    if (pack_act() !== pack_exp()) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, pack_act(), pack_exp());
    end
  endtask

  // expected next values derived from the requirements
  task automatic model();
    logic have, want, fire, iss;
    m_creq = 0; m_dreq = 0; m_data = 0; m_cred = 0;
    if (ev_link_reset || ev_disc_req) begin                 // R9
      m_st = 0; m_cav = 0; m_pend = 0; m_cout = 0;
    end else begin
      case (m_st)
        2'd0: if (cmd_connect) begin                          // R1
          m_st = 1; m_creq = 1; m_err = 0; m_hid = host_id_i; m_fid = fw_id_i;
        end
        2'd1: if (cmd_disconnect) begin m_st = 3; m_dreq = 1; end   // R8
              else if (ev_conn_resp) begin                    // R2
                m_st = ev_conn_ok ? 2'd2 : 2'd0; m_err = !ev_conn_ok;
              end
        2'd2: if (cmd_disconnect) begin
                m_st = 3; m_dreq = 1; m_cav = 0; m_pend = 0; m_cout = 0;
              end else begin                                  // R4 R5 R6 R7
                have = m_cav | ev_credit; want = m_pend | cmd_send;
                fire = have & want;
                m_data = fire; m_cav = have & !fire; m_pend = want & !fire;
                iss = rx_slot_free & !m_cout;
                m_cred = iss; m_cout = (m_cout & !ev_peer_data) | iss;
              end
        default: ;
      endcase
    end
  endtask

  task automatic clear_in();
    {cmd_connect, cmd_disconnect, cmd_send, ev_conn_resp, ev_conn_ok, ev_credit,
     ev_disc_req, ev_link_reset, ev_peer_data, rx_slot_free} = '0;
  endtask

  // drive at negedge, then compare just after the next rising edge
  task automatic step(input logic [9:0] v, input string tag);
    @(negedge clk);
    {cmd_connect, cmd_disconnect, cmd_send, ev_conn_resp, ev_conn_ok, ev_credit,
     ev_disc_req, ev_link_reset, ev_peer_data, rx_slot_free} = v;
    model();
    @(posedge clk); #1;
    check(tag);
  endtask

  // bit positions for step vectors
  localparam logic [9:0] CON = 10'h200, DIS = 10'h100, SND = 10'h080, RSP = 10'h040,
                         OK = 10'h020, CRD = 10'h010, PDR = 10'h008, LRS = 10'h004,
                         PDT = 10'h002, SLF = 10'h001;

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_in(); host_id_i = 8'h05; fw_id_i = 8'h09;
    rst_n = 1'b0;
    m_st = 0; {m_creq, m_dreq, m_data, m_cred, m_cav, m_pend, m_cout, m_err} = '0;
    m_hid = '0; m_fid = '0;
    repeat (3) @(posedge clk);
    #1 check("R10 reset state");
    @(negedge clk) rst_n = 1'b1;

    step(SND, "R3 send while idle ignored");
    step(CON, "R1 connect request");
    host_id_i = 8'h11; fw_id_i = 8'h22;
    step(CON, "R1 connect ignored in CONNECTING");
    step(RSP, "R2 refused response sets error");
    step(CON, "R2 new connect clears error");
    step(RSP | OK, "R2 accepted response opens");
    step(SND, "R5 send without credit pends");
    step(SND, "R6 second send absorbed");
    step(CRD, "R5 credit releases pending send");
    step(CRD, "R4 credit held");
    step(CRD, "R6 second credit absorbed");
    step(SND, "R4 send with held credit");
    step(SND, "R6 send after drained credit pends");
    step(SND | CRD, "R4 send and credit same cycle with pending");
    step(SLF, "R7 grant issued on free slot");
    step(SLF, "R7 no second grant outstanding");
    step(SLF | PDT, "R7 peer data retires grant");
    step(SLF, "R7 new grant after retire");
    step(SND, "R8 pending before local close");
    step(DIS | CRD, "R8 local disconnect flushes");
    step(SND | CRD, "R3 send while closing ignored");
    step(PDR, "R8 peer reply completes close");
    step(CON, "R9 reopen");
    step(RSP | OK, "R9 reopen accepted");
    step(SND | SLF, "R9 build up flags");
    step(LRS | SND | CRD, "R9 link reset wins over send");
    step(CON, "R9 reopen again");
    step(RSP | OK | PDR, "R9 peer disconnect wins over response");

    for (int i = 0; i < 4000; i++) begin
      logic [9:0] v;
      v = 10'($urandom) & 10'($urandom);
      if (($urandom % 16) != 0) v &= ~(LRS | PDR | DIS);
      if (($urandom % 4) == 0) begin
        host_id_i = 8'($urandom); fw_id_i = 8'($urandom);
      end
      step(v, "R1-9 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule